// File: doc/BRIEF.md
# Digit-Serial Lattice Analysis Stage

This block is one stage of a two-channel analysis lattice, built to process its samples a digit at a time. Two two's-complement sample streams, `x` and `y`, arrive as narrow digits, least significant digit first, with a word-start flag on the first digit of every sample. For each sample pair the stage produces `a = x + y/4` and `b = y - x/4`. Here `/4` is an arithmetic right shift by two bits, so it rounds toward minus infinity. Both results wrap to the wordlength. With the default 8-bit words and 2-bit digits, one sample takes four digits. One digit pair is accepted per clock, so the hardware is kept fully busy on a continuous stream.

The multiply by 0.25 costs no multiplier. The scaled operand for digit position i is simply digit i+1 of the other stream. For the top position it is the sign bit repeated. The stage therefore holds each incoming digit pair for one step and combines it with the digit that follows. The last digit of a word needs only its own sign, so it is released without waiting for the next word. A ripple-carry digit adder and a digit subtractor each keep one carry flip-flop. That carry is forced to its start value on digit 0 of every word.

Both ends use valid/ready handshakes. A digit moves when valid and ready are both high at a clock edge. `in_ready` does not depend on `in_valid`. While `out_valid` is high and `out_ready` is low, every output holds still. A stall at the output stops intake as soon as the held digit cannot be released. Digits are never dropped or repeated.

Top module: `dsl_lattice_stage`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For each input word pair, `out_a` carries (x + (y >>> 2)) mod 2^8. Output digit i is bits [2i+1:2i] of the result, sent least significant digit first. Input digit i is likewise bits [2i+1:2i] of the sample.
- R3: For each input word pair, `out_b` carries (y - (x >>> 2)) mod 2^8, with the same digit order as R2.
- R4: `in_first` = 1 marks digit 0 of an input word. `out_first` = 1 on exactly the first of every four output digits, which is digit 0 of a result word.
- R5: No carry or borrow passes from one word into the next. A word that overflows has no effect on the result of the word sent right after it.
- R6: With `out_ready` held at 1 and words offered back to back, `in_ready` stays 1 on every clock. The first output digit of a word is transferred two clocks after its input digit 0 is accepted.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_first`, `out_a` and `out_b` keep their values. Under any pattern of `out_ready`, every word comes out exactly once and in order.
- R8: Idle cycles between the digits of a word do not change the results. The last digit of a word is sent out without waiting for any digit of a following word.
- R9: The scaling is an arithmetic shift. A negative operand is scaled toward minus infinity, so y = -1 scales to -1 and y = -5 scales to -2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input digit pair is present |
| in_ready | output | 1 | Stage accepts an input digit pair this clock |
| in_first | input | 1 | Input digit pair is digit 0 of a word |
| in_x | input | DIGIT_W | Digit of the x stream |
| in_y | input | DIGIT_W | Digit of the y stream |
| out_valid | output | 1 | Output digit pair is present |
| out_ready | input | 1 | Consumer takes the output digit pair this clock |
| out_first | output | 1 | Output digit pair is digit 0 of a result word |
| out_a | output | DIGIT_W | Digit of x + y/4 |
| out_b | output | DIGIT_W | Digit of y - x/4 |

## Verification
The arithmetic is tried with several kinds of input. Hand-picked positive pairs confirm that digits are ordered and the scaled operand is aligned correctly. Negative operands show whether the sign digit is extended or lost. A full-scale overflow word followed by a zero word would expose a carry that leaks between words. A long random stream gives broad coverage of the digit values. The same data is then sent with idle gaps inside words and under a toggling output ready. These runs tell apart a stage that computes correctly only on an unbroken stream from one that keeps its carry and hold state through stalls. The same runs check that the final digit drains on its own.

// File: rtl/dsl_pkg.sv
`timescale 1ns/1ps
package dsl_pkg;
  localparam int DSL_WORD_W  = 8;
  localparam int DSL_DIGIT_W = 2;

  typedef enum logic {
    DSL_ADD = 1'b0,
    DSL_SUB = 1'b1
  } dsl_op_e;
endpackage

// File: rtl/dsl_adder.sv
`timescale 1ns/1ps
module dsl_adder
  import dsl_pkg::*;
#(
  parameter int      DIGIT_W = DSL_DIGIT_W,
  parameter dsl_op_e OP      = DSL_ADD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               first,
  input  logic [DIGIT_W-1:0] lhs,
  input  logic [DIGIT_W-1:0] rhs,
  output logic [DIGIT_W-1:0] sum
);
  logic               carry_q;
  logic               cin;
  logic [DIGIT_W-1:0] rhs_eff;
  logic [DIGIT_W:0]   wide;

  // Subtraction adds the inverted operand with a carry of one into digit 0.
  generate
    if (OP == DSL_SUB) begin : g_sub
      assign rhs_eff = ~rhs;
      assign cin     = first ? 1'b1 : carry_q;
    end else begin : g_add
      assign rhs_eff = rhs;
      assign cin     = first ? 1'b0 : carry_q;
    end
  endgenerate

  assign wide = {1'b0, lhs} + {1'b0, rhs_eff} + {{DIGIT_W{1'b0}}, cin};
  assign sum  = wide[DIGIT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  carry_q <= 1'b0;
    else if (en) carry_q <= wide[DIGIT_W];
  end
endmodule

// File: rtl/dsl_align.sv
`timescale 1ns/1ps
module dsl_align
  import dsl_pkg::*;
#(
  parameter int WORD_W  = DSL_WORD_W,
  parameter int DIGIT_W = DSL_DIGIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_first,
  input  logic [DIGIT_W-1:0] in_x,
  input  logic [DIGIT_W-1:0] in_y,
  input  logic               out_can,
  output logic               in_ready,
  output logic               fire,
  output logic               hold_first,
  output logic [DIGIT_W-1:0] hold_x,
  output logic [DIGIT_W-1:0] hold_y,
  output logic [DIGIT_W-1:0] scl_x,
  output logic [DIGIT_W-1:0] scl_y
);
  localparam int NDIG  = WORD_W / DIGIT_W;
  localparam int POS_W = $clog2(NDIG);
  localparam logic [POS_W-1:0] LAST = POS_W'(NDIG - 1);

  generate
    if ((WORD_W % DIGIT_W) != 0 || NDIG < 2) begin : g_bad_cfg
      $error("digit size must divide the wordlength into at least two digits");
    end
  endgenerate

  logic             hold_v;
  logic [POS_W-1:0] hold_pos;
  logic [POS_W-1:0] next_pos;
  logic [POS_W-1:0] in_pos;
  logic             at_last;
  logic             take;

  assign at_last    = (hold_pos == LAST);
  assign in_ready   = !hold_v || out_can;
  assign take       = in_valid && in_ready;
  assign fire       = hold_v && out_can && (at_last || in_valid);
  assign hold_first = (hold_pos == '0);
  assign in_pos     = in_first ? '0 : next_pos;

  // Scaled operand: the next digit of the other stream, or its sign on the top digit.
  assign scl_x = at_last ? {DIGIT_W{hold_x[DIGIT_W-1]}} : in_x;
  assign scl_y = at_last ? {DIGIT_W{hold_y[DIGIT_W-1]}} : in_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_pos <= '0;
      hold_x   <= '0;
      hold_y   <= '0;
      next_pos <= '0;
    end else if (take) begin
      hold_v   <= 1'b1;
      hold_x   <= in_x;
      hold_y   <= in_y;
      hold_pos <= in_pos;
      next_pos <= (in_pos == LAST) ? '0 : in_pos + POS_W'(1);
    end else if (fire) begin
      hold_v   <= 1'b0;
    end
  end

  // R4: a released inner digit is followed in the hold register by its successor.
  p_pos_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !at_last |=> hold_v && (hold_pos == $past(hold_pos) + POS_W'(1)));

  // R8: the top digit leaves without waiting; only a new word's digit 0 may follow.
  p_last_drains_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && at_last && out_can |=> !hold_v || (hold_pos == '0));
endmodule

// File: rtl/dsl_lattice_stage.sv
`timescale 1ns/1ps
module dsl_lattice_stage
  import dsl_pkg::*;
#(
  parameter int WORD_W  = DSL_WORD_W,
  parameter int DIGIT_W = DSL_DIGIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_first,
  input  logic [DIGIT_W-1:0] in_x,
  input  logic [DIGIT_W-1:0] in_y,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_first,
  output logic [DIGIT_W-1:0] out_a,
  output logic [DIGIT_W-1:0] out_b
);
  localparam int NDIG  = WORD_W / DIGIT_W;
  localparam int POS_W = $clog2(NDIG);

  logic               out_can;
  logic               fire;
  logic               hold_first;
  logic [DIGIT_W-1:0] hold_x, hold_y, scl_x, scl_y;
  logic [DIGIT_W-1:0] sum_a, sum_b;

  assign out_can = !out_valid || out_ready;

  dsl_align #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u_align (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_first(in_first), .in_x(in_x), .in_y(in_y),
    .out_can(out_can), .in_ready(in_ready), .fire(fire),
    .hold_first(hold_first), .hold_x(hold_x), .hold_y(hold_y),
    .scl_x(scl_x), .scl_y(scl_y)
  );

  dsl_adder #(.DIGIT_W(DIGIT_W), .OP(DSL_ADD)) u_sum_a (
    .clk(clk), .rst_n(rst_n), .en(fire), .first(hold_first),
    .lhs(hold_x), .rhs(scl_y), .sum(sum_a)
  );

  dsl_adder #(.DIGIT_W(DIGIT_W), .OP(DSL_SUB)) u_dif_b (
    .clk(clk), .rst_n(rst_n), .en(fire), .first(hold_first),
    .lhs(hold_y), .rhs(scl_x), .sum(sum_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_a     <= '0;
      out_b     <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_first <= hold_first;
      out_a     <= sum_a;
      out_b     <= sum_b;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Checker state: position of the next output digit within its word.
  logic [POS_W-1:0] chk_out_pos;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_out_pos <= '0;
    else if (out_valid && out_ready)
      chk_out_pos <= (chk_out_pos == POS_W'(NDIG - 1)) ? '0 : chk_out_pos + POS_W'(1);
  end

  // R4: the word-start flag appears only on the first digit of every group.
  p_out_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_first |-> chk_out_pos == '0);

  // R6: a released digit is presented on the next clock.
  p_fire_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R7: a stalled output digit stays put.
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_a) && $stable(out_b)
                                 && $stable(out_first));
endmodule

// File: tb/test_dsl_lattice_stage.sv
`timescale 1ns/1ps
module test_dsl_lattice_stage;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_first;
  logic [1:0] in_x, in_y;
  logic       out_valid, out_ready, out_first;
  logic [1:0] out_a, out_b;

  dsl_lattice_stage i_dsl_lattice_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first),
    .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_first(out_first),
    .out_a(out_a), .out_b(out_b)
  );

  always #(HALF) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, stalls = 0, sent = 0, got = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  got_a[$], got_b[$];
  int          got_cyc[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic signed [7:0] x, input logic signed [7:0] y);
    logic signed [7:0] a, b;
    a = x + (y >>> 2);
    b = y - (x >>> 2);
    return {a, b};
  endfunction

  // Output monitor: samples one time unit before each rising edge.
  int         mpos = 0;
  logic [7:0] wa, wb;
  bit         frame_ok = 1;
  bit         held = 0;
  logic [4:0] held_vals;
  always begin
    @(negedge clk);
    #(HALF - 1);
    if (held) begin
      check(out_valid && ({out_first, out_a, out_b} == held_vals), "R7",
            "stalled output changed", {out_valid, out_first, out_a, out_b}, {1'b1, held_vals});
      held = 0;
    end
    if (out_valid && !out_ready) begin
      held = 1;
      held_vals = {out_first, out_a, out_b};
    end
    if (out_valid && out_ready) begin
      if (mpos == 0) got_cyc.push_back(cyc);
      if (out_first != (mpos == 0)) frame_ok = 0;
      wa[2*mpos +: 2] = out_a;
      wb[2*mpos +: 2] = out_b;
      if (mpos == 3) begin
        logic [15:0] e;
        if (exp_q.size() == 0) begin
          check(0, "R7", "word with no expected entry", {wa, wb}, 0);
        end else begin
          e = exp_q.pop_front();
          check(wa == e[15:8], "R2", "out_a word", wa, e[15:8]);
          check(wb == e[7:0], "R3", "out_b word", wb, e[7:0]);
        end
        check(frame_ok, "R4", "out_first placement", 0, 1);
        got_a.push_back(wa);
        got_b.push_back(wb);
        got++;
        mpos = 0;
        frame_ok = 1;
      end else begin
        mpos++;
      end
    end
  end

  task automatic push_digit(input logic [1:0] dx, input logic [1:0] dy, input logic f,
                            output int acc);
    @(negedge clk);
    in_valid = 1'b1; in_x = dx; in_y = dy; in_first = f;
    forever begin
      #(HALF - 1);
      if (in_ready) break;
      stalls++;
      @(negedge clk);
    end
    acc = cyc;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [7:0] x, input logic [7:0] y, input int gap,
                           output int acc0);
    int acc;
    exp_q.push_back(model(x, y));
    sent++;
    acc0 = 0;
    for (int i = 0; i < 4; i++) begin
      repeat (gap) @(negedge clk);
      push_digit(x[2*i +: 2], y[2*i +: 2], i == 0, acc);
      if (i == 0) acc0 = acc;
    end
  endtask

  task automatic wait_drain(input string req);
    int n = 0;
    while (got != sent && n < 400) begin
      @(posedge clk);
      n++;
    end
    repeat (2) @(posedge clk);
    check(got == sent, req, "words received", got, sent);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #(HALF - 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_single();
    int acc, base, n;
    base = got;
    send_word(8'h35, 8'h6C, 0, acc);
    n = 0;
    while (got == base && n < 6) begin
      @(posedge clk);
      n++;
    end
    check(got == base + 1, "R8", "last digit drained without next word", got, base + 1);
    check(got_a[base] == 8'd80, "R2", "a for 0x35/0x6C", got_a[base], 80);
    check(got_b[base] == 8'd95, "R3", "b for 0x35/0x6C", got_b[base], 95);
  endtask

  task automatic t_sign();
    int acc, base;
    base = got;
    send_word(8'h00, 8'hFF, 0, acc);
    send_word(8'h80, 8'h80, 0, acc);
    send_word(8'h01, 8'hFB, 0, acc);
    wait_drain("R9");
    check(got_a[base] == 8'hFF, "R9", "0 + (-1)/4", got_a[base], 8'hFF);
    check(got_a[base+1] == 8'h60, "R9", "-128 + (-128)/4", got_a[base+1], 8'h60);
    check(got_b[base+1] == 8'hA0, "R9", "-128 - (-128)/4", got_b[base+1], 8'hA0);
    check(got_a[base+2] == 8'hFF, "R9", "1 + (-5)/4", got_a[base+2], 8'hFF);
  endtask

  task automatic t_carry_iso();
    int acc, base;
    base = got;
    send_word(8'h7F, 8'h7F, 0, acc);
    send_word(8'h00, 8'h00, 0, acc);
    send_word(8'h80, 8'h7F, 0, acc);
    send_word(8'h00, 8'h00, 0, acc);
    wait_drain("R5");
    check(got_a[base] == 8'h9E, "R5", "overflowing a wraps", got_a[base], 8'h9E);
    check(got_a[base+1] == 8'h00 && got_b[base+1] == 8'h00, "R5",
          "zero word after overflow", {got_a[base+1], got_b[base+1]}, 0);
    check(got_a[base+3] == 8'h00 && got_b[base+3] == 8'h00, "R5",
          "zero word after borrow", {got_a[base+3], got_b[base+3]}, 0);
  endtask

  task automatic t_stream();
    int acc, first_acc, base, st0;
    base = got;
    st0 = stalls;
    for (int w = 0; w < 40; w++) begin
      send_word(8'($urandom), 8'($urandom), 0, acc);
      if (w == 0) first_acc = acc;
    end
    wait_drain("R6");
    check(stalls == st0, "R6", "in_ready stalls on continuous stream", stalls - st0, 0);
    check(got_cyc[base] - first_acc == 2, "R6", "latency of digit 0",
          got_cyc[base] - first_acc, 2);
  endtask

  task automatic t_backpressure();
    int acc;
    fork
      begin
        for (int w = 0; w < 12; w++) send_word(8'($urandom), 8'($urandom), 0, acc);
      end
      begin
        for (int i = 0; i < 70; i++) begin
          @(posedge clk);
          #1;
          out_ready = ((i % 3) != 0) && ((i % 7) != 5);
        end
        @(posedge clk);
        #1;
        out_ready = 1'b1;
      end
    join
    wait_drain("R7");
  endtask

  task automatic t_gaps();
    int acc, base;
    base = got;
    send_word(8'h35, 8'h6C, 2, acc);
    send_word(8'hC4, 8'h9B, 3, acc);
    send_word(8'h7F, 8'h80, 1, acc);
    wait_drain("R8");
    check(got_a[base] == 8'd80 && got_b[base] == 8'd95, "R8", "gapped word result",
          {got_a[base], got_b[base]}, {8'd80, 8'd95});
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    report();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0;
    in_x = '0; in_y = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_sign();
    t_carry_iso();
    t_stream();
    t_backpressure();
    t_gaps();
    repeat (4) @(posedge clk);
    report();
  end
endmodule